// File: doc/BRIEF.md
# Transmit Descriptor Ring Manager

This block feeds a network transmitter from a ring of descriptors kept in shared memory. Software fills descriptors, then moves a produce index forward. Whenever the produce index differs from the consume index, the block fetches the two-word descriptor at the consume position. It reads the fragment bytes it points to and hands them out one by one on a byte stream. It then writes one status word into a status array that runs alongside the descriptor ring, and moves the consume index forward.

A frame may be split over several fragment descriptors. Only the descriptor whose Last flag is set closes the frame. That descriptor waits for the MAC to report completion and any errors. A frame whose following fragment has not been supplied yet is cut short and marked as missing a descriptor.

An interrupt status register records three events: the completion of a descriptor that asked for an interrupt, a transmit error, and the ring running empty. A separate enable mask gates only the interrupt line. Software clears status bits by writing ones to them.

Top module: `txring_mgr`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, `tx_valid` is low and no memory request is pending. The register word addresses are: 0 descriptor base, 1 status base, 2 ring size minus one, 3 produce index, 4 consume index (read only), 5 interrupt status (read only), 6 interrupt enable, 7 interrupt clear (write only).
- R2: Descriptor `i` occupies two words at descriptor base + 8·i. The first word is the fragment byte address. The second is the control word, whose bits [10:0] hold the length minus one, bit 30 is Last and bit 31 is Interrupt. Fragment bytes leave in ascending address order at any alignment. Byte lane n of a memory word is bits [8n+7:8n].
- R3: `tx_last` is high on the final byte of a fragment whose Last bit is set, and on no other byte. While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R4: With produce equal to consume the block stays idle and issues no memory request. After it reaches the ring-size register value, the consume index wraps to zero.
- R5: The status word of descriptor `i` is written at status base + 4·i. Its bits [10:0] copy the control length field.
- R6: If a fragment without Last completes while the next index equals the produce index, the block does the following. It writes status bits 31 and 30. It sets interrupt status bit 1. It pulses `tx_abort` for one cycle and emits no `tx_last`.
- R7: For a Last fragment, the error flags reported with `mac_done` are stored in status bits [29:26]: late collision, excessive collision, excessive deferral, underrun/overrun. Bit 31 is set if any flag is set, and any flag sets interrupt status bit 1.
- R8: Processing a descriptor with the Interrupt bit sets interrupt status bit 0. Each advance that leaves consume equal to produce sets interrupt status bit 2.
- R9: `irq` is the OR of status bits ANDed with their enables, registered one cycle. Writing the enable register never changes interrupt status.
- R10: Writing ones to the clear register clears those status bits and leaves the others and the enables unchanged. A new event wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle completion of the pending request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Transmitter accepts the byte |
| tx_abort | output | 1 | Pulse: frame ended because a fragment was missing |
| mac_done | input | 1 | Pulse: transmitter finished the frame |
| mac_err | input | 4 | Error flags valid with `mac_done` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the missing-fragment error. It needs a fragment without Last to finish streaming at a moment when software has published exactly that descriptor and no more. The bench reaches it by writing a lone non-Last descriptor and moving the produce index by one. It then expects the aborted status word, the abort pulse and the error status bit. Wrap of the consume index and word-boundary crossings inside a fragment are reached by the order of the vector table, with a throttled `tx_ready` on the later entries.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int SIZE_W        = 11;
  localparam int CTRL_LAST_BIT = 30;
  localparam int CTRL_INT_BIT  = 31;
  localparam int NUM_IRQ       = 3;

  localparam logic [2:0] RA_DESC  = 3'd0;
  localparam logic [2:0] RA_STAT  = 3'd1;
  localparam logic [2:0] RA_COUNT = 3'd2;
  localparam logic [2:0] RA_PROD  = 3'd3;
  localparam logic [2:0] RA_CONS  = 3'd4;
  localparam logic [2:0] RA_ISTAT = 3'd5;
  localparam logic [2:0] RA_IEN   = 3'd6;
  localparam logic [2:0] RA_ICLR  = 3'd7;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CTRL, S_FILL, S_SEND, S_MAC, S_STAT, S_ADV
  } eng_state_t;
endpackage

// File: rtl/txring_regs.sv
module txring_regs
  import txring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [IDX_W-1:0]  consume,
  input  logic              evt_done,
  input  logic              evt_err,
  input  logic              evt_drain,
  output logic [ADDR_W-1:0] desc_base,
  output logic [ADDR_W-1:0] stat_base,
  output logic [IDX_W-1:0]  ring_last,
  output logic [IDX_W-1:0]  produce,
  output logic              irq
);
  logic [NUM_IRQ-1:0] int_stat, int_en, set_mask, clr_mask;

  assign set_mask = {evt_drain, evt_err, evt_done};
  assign clr_mask = (reg_we && reg_addr == RA_ICLR) ? reg_wdata[NUM_IRQ-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_base <= '0;
      stat_base <= '0;
      ring_last <= '0;
      produce   <= '0;
      int_en    <= '0;
      int_stat  <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RA_DESC:  desc_base <= reg_wdata[ADDR_W-1:0];
          RA_STAT:  stat_base <= reg_wdata[ADDR_W-1:0];
          RA_COUNT: ring_last <= reg_wdata[IDX_W-1:0];
          RA_PROD:  produce   <= reg_wdata[IDX_W-1:0];
          RA_IEN:   int_en    <= reg_wdata[NUM_IRQ-1:0];
          default: ;
        endcase
      end
      int_stat <= (int_stat & ~clr_mask) | set_mask;
      irq      <= |(int_stat & int_en);
      case (reg_addr)
        RA_DESC:  reg_rdata <= 32'(desc_base);
        RA_STAT:  reg_rdata <= 32'(stat_base);
        RA_COUNT: reg_rdata <= 32'(ring_last);
        RA_PROD:  reg_rdata <= 32'(produce);
        RA_CONS:  reg_rdata <= 32'(consume);
        RA_ISTAT: reg_rdata <= 32'(int_stat);
        RA_IEN:   reg_rdata <= 32'(int_en);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  a_r10_clear_keeps_enable: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RA_ICLR) |=> $stable(int_en));
  a_r9_enable_keeps_status: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RA_IEN && !evt_done && !evt_err && !evt_drain) |=> $stable(int_stat));
  a_r8_done_recorded: assert property (@(posedge clk) disable iff (rst)
    evt_done |=> int_stat[0]);
  a_r6_error_recorded: assert property (@(posedge clk) disable iff (rst)
    evt_err |=> int_stat[1]);
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [ADDR_W-1:0] stat_base,
  input  logic [IDX_W-1:0]  ring_last,
  input  logic [IDX_W-1:0]  produce,
  output logic [IDX_W-1:0]  consume,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              tx_abort,
  input  logic              mac_done,
  input  logic [3:0]        mac_err,
  output logic              evt_done,
  output logic              evt_err,
  output logic              evt_drain
);
  eng_state_t        state;
  logic [ADDR_W-1:0] buf_ptr;
  logic [SIZE_W-1:0] left, size_q;
  logic              ctrl_last, ctrl_int, nodesc_q;
  logic [31:0]       word_q;
  logic [3:0]        err_q;
  logic [IDX_W-1:0]  next_idx;
  logic [ADDR_W-1:0] desc_addr, stat_addr;

  assign next_idx  = (consume == ring_last) ? '0 : consume + IDX_W'(1);
  assign desc_addr = desc_base + (ADDR_W'(consume) << 3);
  assign stat_addr = stat_base + (ADDR_W'(consume) << 2);

  function automatic logic [7:0] lane(input logic [31:0] w, input logic [1:0] s);
    return w[8*s +: 8];
  endfunction

  function automatic logic [31:0] stat_word(input logic nd, input logic [3:0] e,
                                            input logic [SIZE_W-1:0] sz);
    return {(nd | (|e)), nd, e, (32-6-SIZE_W)'(0), sz};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      consume   <= '0;
      buf_ptr   <= '0;
      left      <= '0;
      size_q    <= '0;
      ctrl_last <= 1'b0;
      ctrl_int  <= 1'b0;
      nodesc_q  <= 1'b0;
      word_q    <= '0;
      err_q     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      tx_last   <= 1'b0;
      tx_abort  <= 1'b0;
      evt_done  <= 1'b0;
      evt_err   <= 1'b0;
      evt_drain <= 1'b0;
    end else begin
      tx_abort  <= 1'b0;
      evt_done  <= 1'b0;
      evt_err   <= 1'b0;
      evt_drain <= 1'b0;
      case (state)
        S_IDLE: if (produce != consume) begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= desc_addr;
          state    <= S_ADDR;
        end
        S_ADDR: if (mem_ack) begin
          buf_ptr  <= mem_rdata[ADDR_W-1:0];
          mem_addr <= desc_addr + ADDR_W'(4);
          state    <= S_CTRL;
        end
        S_CTRL: if (mem_ack) begin
          left      <= mem_rdata[SIZE_W-1:0];
          size_q    <= mem_rdata[SIZE_W-1:0];
          ctrl_last <= mem_rdata[CTRL_LAST_BIT];
          ctrl_int  <= mem_rdata[CTRL_INT_BIT];
          mem_addr  <= {buf_ptr[ADDR_W-1:2], 2'b00};
          state     <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          mem_req  <= 1'b0;
          word_q   <= mem_rdata;
          tx_valid <= 1'b1;
          tx_data  <= lane(mem_rdata, buf_ptr[1:0]);
          tx_last  <= ctrl_last && (left == '0);
          state    <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          buf_ptr <= buf_ptr + ADDR_W'(1);
          if (left == '0) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            if (ctrl_last) begin
              state <= S_MAC;
            end else begin
              nodesc_q  <= (next_idx == produce);
              err_q     <= '0;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= stat_addr;
              mem_wdata <= stat_word(next_idx == produce, 4'b0, size_q);
              state     <= S_STAT;
            end
          end else begin
            left <= left - SIZE_W'(1);
            if (buf_ptr[1:0] == 2'd3) begin
              tx_valid <= 1'b0;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= buf_ptr + ADDR_W'(1);
              state    <= S_FILL;
            end else begin
              tx_data <= lane(word_q, buf_ptr[1:0] + 2'd1);
              tx_last <= ctrl_last && (left == SIZE_W'(1));
            end
          end
        end
        S_MAC: if (mac_done) begin
          err_q     <= mac_err;
          nodesc_q  <= 1'b0;
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= stat_addr;
          mem_wdata <= stat_word(1'b0, mac_err, size_q);
          state     <= S_STAT;
        end
        S_STAT: if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          state   <= S_ADV;
        end
        S_ADV: begin
          consume   <= next_idx;
          evt_done  <= ctrl_int;
          evt_err   <= nodesc_q | (|err_q);
          evt_drain <= (next_idx == produce);
          tx_abort  <= nodesc_q;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_stream_holds: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  a_r2_mem_request_holds: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r4_consume_steps: assert property (@(posedge clk) disable iff (rst)
    !$stable(consume) |-> (consume == '0 || consume == $past(consume) + IDX_W'(1)));
  a_r4_idle_when_empty: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && produce == consume) |=> (state == S_IDLE && !mem_req));
  a_r6_abort_without_last: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> !tx_valid);
endmodule

// File: rtl/txring_mgr.sv
module txring_mgr
  import txring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              tx_abort,
  input  logic              mac_done,
  input  logic [3:0]        mac_err,
  output logic              irq
);
  logic [ADDR_W-1:0] desc_base, stat_base;
  logic [IDX_W-1:0]  ring_last, produce, consume;
  logic              evt_done, evt_err, evt_drain;

  txring_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .consume(consume),
    .evt_done(evt_done), .evt_err(evt_err), .evt_drain(evt_drain),
    .desc_base(desc_base), .stat_base(stat_base), .ring_last(ring_last), .produce(produce),
    .irq(irq)
  );

  txring_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_engine (
    .clk(clk), .rst(rst),
    .desc_base(desc_base), .stat_base(stat_base), .ring_last(ring_last), .produce(produce),
    .consume(consume),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .tx_abort(tx_abort), .mac_done(mac_done), .mac_err(mac_err),
    .evt_done(evt_done), .evt_err(evt_err), .evt_drain(evt_drain)
  );
endmodule

// File: tb/txring_mgr_bench.sv
module txring_mgr_bench;
  localparam int CLK_P = 10;
  // entry: [11:0] buf addr, [22:12] len-1, [23] last, [24] intr, [25] publish, [29:26] mac errors
  localparam logic [29:0] VEC [6] = '{
    {4'b0000, 1'b0, 1'b0, 1'b0, 11'd7,  12'h314},
    {4'b0000, 1'b1, 1'b1, 1'b1, 11'd11, 12'h341},
    {4'b1000, 1'b1, 1'b0, 1'b1, 11'd7,  12'h324},
    {4'b0000, 1'b1, 1'b1, 1'b1, 11'd2,  12'h3F3},
    {4'b0000, 1'b0, 1'b0, 1'b0, 11'd0,  12'h300},
    {4'b0001, 1'b1, 1'b0, 1'b1, 11'd15, 12'h380}
  };

  logic clk = 0, rst = 1;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic tx_valid, tx_last, tx_ready = 1, tx_abort, irq;
  logic [7:0] tx_data;
  logic mac_done = 0;
  logic [3:0] mac_err = 0, cur_err = 0;
  logic stall = 0;
  logic [31:0] mem [0:255];
  logic [7:0] exp_d [0:511];
  logic exp_l [0:511];
  int wr = 0, rd = 0, tests = 0, fails = 0, aborts = 0, cyc = 0;

  txring_mgr u_txring_mgr (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .tx_abort(tx_abort), .mac_done(mac_done), .mac_err(mac_err), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
    cyc <= cyc + 1;
    tx_ready <= stall ? (cyc % 3 != 0) : 1'b1;
    mac_done <= tx_valid && tx_ready && tx_last;
    mac_err  <= (tx_valid && tx_ready && tx_last) ? cur_err : 4'b0;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (tx_abort) aborts++;
    if (!rst && tx_valid && tx_ready) begin
      check(rd < wr && tx_data == exp_d[rd], "R2 byte order", 32'(tx_data), 32'(exp_d[rd]));
      check(tx_last == exp_l[rd], "R3 last marker", 32'(tx_last), 32'(exp_l[rd]));
      rd++;
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_consume(input int target);
    logic [31:0] v;
    for (int t = 0; t < 3000; t++) begin
      rreg(3'd4, v);
      if (v == 32'(target)) return;
    end
    check(0, "R4 consume timeout", v, 32'(target));
  endtask

  task automatic put_desc(input int di, input int addr, input int len1, input bit last, input bit intr);
    mem[(32'h100 + 8*di) >> 2]     = 32'(addr);
    mem[((32'h100 + 8*di) >> 2) + 1] = {intr, last, 19'b0, 11'(len1)};
    for (int k = 0; k <= len1; k++) begin
      exp_d[wr] = pat(addr + k);
      exp_l[wr] = last && (k == len1);
      wr++;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int di, np;
    int pend [4];
    for (int w = 0; w < 256; w++) mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    repeat (5) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rreg(3'(a), v);
      check(v == 0, "R1 register reset", v, 0);
    end
    check(!tx_valid && !irq && !mem_req, "R1 outputs idle", {tx_valid, irq, mem_req}, 0);

    wreg(3'd0, 32'h100);
    wreg(3'd1, 32'h200);
    wreg(3'd2, 32'd3);
    wreg(3'd6, 32'd7);

    di = 0; np = 0;
    for (int i = 0; i < 6; i++) begin
      logic [29:0] e;
      logic [2:0] exp_int;
      e = VEC[i];
      if (i >= 3) stall = 1;
      put_desc(di, int'(e[11:0]), int'(e[22:12]), e[23], e[24]);
      pend[np++] = di;
      di = (di == 3) ? 0 : di + 1;
      if (e[25]) begin
        cur_err = e[29:26];
        wreg(3'd3, 32'(di));
        wait_consume(di);
        repeat (4) @(negedge clk);
        exp_int = 3'b100;
        for (int p = 0; p < np; p++) begin
          logic [29:0] f;
          logic [3:0] fe;
          logic [31:0] sw;
          f = VEC[i - np + 1 + p];
          fe = f[23] ? f[29:26] : 4'b0;
          sw = {|fe, 1'b0, fe, 15'b0, f[22:12]};
          // R5 status placement and length copy; R7 MAC error flags
          check(mem[(32'h200 + 4*pend[p]) >> 2] == sw, "R5/R7 status word",
                mem[(32'h200 + 4*pend[p]) >> 2], sw);
          if (f[24]) exp_int[0] = 1;
          if (|fe) exp_int[1] = 1;
        end
        rreg(3'd5, v);
        check(v == 32'(exp_int), "R8 interrupt status", v, 32'(exp_int));
        check(irq == 1, "R9 irq with enables", 32'(irq), 1);
        wreg(3'd7, 32'd7);
        rreg(3'd5, v);
        check(v == 0, "R10 clear all", v, 0);
        np = 0;
      end
    end
    stall = 0;
    check(rd == wr, "R2 byte count", rd, wr);
    rreg(3'd4, v);
    check(v == 2, "R4 consume wrapped", v, 2);
    repeat (20) @(negedge clk);
    check(!mem_req && !tx_valid, "R4 idle on empty ring", {mem_req, tx_valid}, 0);

    // R6 missing next fragment
    put_desc(2, 'h3A0, 3, 1'b0, 1'b0);
    wreg(3'd3, 32'd3);
    wait_consume(3);
    repeat (4) @(negedge clk);
    check(mem[(32'h200 + 8) >> 2] == {2'b11, 4'b0, 15'b0, 11'd3}, "R6 status word",
          mem[(32'h200 + 8) >> 2], {2'b11, 4'b0, 15'b0, 11'd3});
    check(aborts == 1, "R6 abort pulse", aborts, 1);
    check(rd == wr, "R6 fragment bytes", rd, wr);
    rreg(3'd5, v);
    check(v == 32'd6, "R6 error status bit", v, 6);

    // R9 enables gate only the line
    wreg(3'd6, 32'd0);
    repeat (3) @(negedge clk);
    check(irq == 0, "R9 irq masked", 32'(irq), 0);
    rreg(3'd5, v);
    check(v == 32'd6, "R9 status kept when masked", v, 6);
    wreg(3'd6, 32'd2);
    repeat (3) @(negedge clk);
    check(irq == 1, "R9 irq unmasked", 32'(irq), 1);
    // R10 partial clear
    wreg(3'd7, 32'd2);
    rreg(3'd5, v);
    check(v == 32'd4, "R10 partial clear", v, 4);
    rreg(3'd6, v);
    check(v == 32'd2, "R10 enable untouched", v, 2);
    repeat (3) @(negedge clk);
    check(irq == 0, "R9 irq after clear", 32'(irq), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule